// File: doc/BRIEF.md
# Transmit/Receive Antenna Switch Controller

This block drives the RF switch and path-enable lines of a transceiver slot that has two antenna connectors: a shared port that can serve either the transmitter or the receiver, and a receive-only port. In half-duplex operation a four-state machine moves the shared port to the transmit side while transmit samples are streaming. When streaming has been quiet for a programmable hold time, it moves the port back to the receiver on its own.

In full-duplex operation the receiver takes its input from the receive-only port and the shared port stays on the transmit side, so both paths run at once. Software can set an override enable and drive all four lines from a 4-bit field. The state machine keeps following activity while the override is set, so the outputs are correct at the moment the override is released.

Both enable lines follow the switch with a one-cycle guard. The transmit enable rises one cycle after the shared port reaches the transmit side. It falls one cycle before the port leaves it.

Top module: `trx_switch_ctl`

## Requirements
- R1: Out of reset, the shared port is on the receive side (`shared_tx`=0), the receiver uses the shared port (`rx_from_rx2`=0), `rx_en`=1 and `tx_en`=0. This is the default port selection.
- R2: In half-duplex mode (`full_dup`=0), the first clock edge that samples `tx_busy`=1 while idle sets `shared_tx`=1 and `rx_en`=0 at that edge. While `rx_from_rx2`=0, `rx_en` and `shared_tx` are never both 1.
- R3: `tx_en` rises exactly one clock edge after `shared_tx` rises.
- R4: After transmit activity ends, `tx_en` falls at the edge where `tx_busy` has been sampled low on M+1 consecutive edges, where M is the larger of `hold_cycles` and 1.
- R5: `shared_tx` returns to 0 and `rx_en` returns to 1 one edge after `tx_en` falls, with no software action.
- R6: If `tx_busy` returns high after being low on at most M consecutive edges, `shared_tx` and `tx_en` stay at 1 throughout.
- R7: The first edge that samples `full_dup`=1 sets `shared_tx`=1, `rx_from_rx2`=1 and `rx_en`=1. `tx_en` follows one edge later. In this mode `tx_busy` has no effect on the outputs.
- R8: The first edge that samples `full_dup`=0 after full-duplex mode clears `tx_en`. With `tx_busy` low, the next edge clears `shared_tx` and `rx_from_rx2`. `rx_en` stays 1 throughout.
- R9: While `ovr_en`=1, the outputs follow `ovr_bits` combinationally: bit 0 drives `shared_tx`, bit 1 drives `tx_en`, bit 2 drives `rx_en` and bit 3 drives `rx_from_rx2`.
- R10: `tx_en` is never 1 while `shared_tx` is 0, in any mode, including override. The receive-only port is never routed to the transmitter.
- R11: The state machine follows `tx_busy` while the override is set. Releasing the override shows the state reached under automatic control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_busy | input | 1 | High while transmit samples are streaming |
| full_dup | input | 1 | 1 selects full-duplex port mapping, 0 selects half-duplex |
| hold_cycles | input | HOLD_W | Quiet time before transmit is considered stopped |
| ovr_en | input | 1 | Software override enable |
| ovr_bits | input | 4 | Override values {rx_from_rx2, rx_en, tx_en, shared_tx} |
| shared_tx | output | 1 | Shared port connected to the transmit path |
| rx_from_rx2 | output | 1 | Receiver input taken from the receive-only port |
| tx_en | output | 1 | Transmit path enable |
| rx_en | output | 1 | Receive path enable |

## Verification
The bench builds the block with HOLD_W=4. This keeps the hold window small enough to sweep `hold_cycles` from 0 to 4 against every transmit burst length from 1 to 4 cycles. It also reaches every quiet gap that is just short of the release point. The small width brings the zero-hold floor and the release edge within reach of a single run, as well as both full-duplex entry paths. All sixteen override codes are applied, including those that request transmit while the port is on the receive side.

// File: rtl/trx_switch_ctl.sv
module trx_switch_ctl #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_busy,
  input  logic              full_dup,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              ovr_en,
  input  logic [3:0]        ovr_bits,
  output logic              shared_tx,
  output logic              rx_from_rx2,
  output logic              tx_en,
  output logic              rx_en
);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_HOLD, S_FULL} state_t;

  state_t            state;
  logic [HOLD_W-1:0] quiet;
  logic              sw_q, rx2_q, txen_q, rxen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      quiet  <= '0;
      sw_q   <= 1'b0;
      rx2_q  <= 1'b0;
      txen_q <= 1'b0;
      rxen_q <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (full_dup) begin
            state  <= S_FULL;
            sw_q   <= 1'b1;
            rx2_q  <= 1'b1;
            rxen_q <= 1'b1;
          end else if (tx_busy) begin
            state  <= S_TX;
            sw_q   <= 1'b1;
            rxen_q <= 1'b0;
          end
        end
        S_TX: begin
          txen_q <= sw_q;
          if (full_dup) begin
            state  <= S_FULL;
            rx2_q  <= 1'b1;
            rxen_q <= 1'b1;
          end else if (!tx_busy) begin
            state <= S_HOLD;
            quiet <= {{(HOLD_W-1){1'b0}}, 1'b1};
          end
        end
        S_HOLD: begin
          if (full_dup) begin
            state  <= S_FULL;
            rx2_q  <= 1'b1;
            rxen_q <= 1'b1;
            txen_q <= sw_q;
          end else if (tx_busy) begin
            state  <= S_TX;
            rx2_q  <= 1'b0;
            rxen_q <= 1'b0;
          end else if (!txen_q) begin
            state  <= S_IDLE;
            sw_q   <= 1'b0;
            rx2_q  <= 1'b0;
            rxen_q <= 1'b1;
          end else if (quiet >= hold_cycles) begin
            txen_q <= 1'b0;
          end else begin
            quiet <= quiet + 1'b1;
          end
        end
        default: begin
          txen_q <= sw_q;
          if (!full_dup) begin
            state  <= S_HOLD;
            txen_q <= 1'b0;
            quiet  <= {{(HOLD_W-1){1'b0}}, 1'b1};
          end
        end
      endcase
    end
  end

  assign shared_tx   = ovr_en ? ovr_bits[0] : sw_q;
  assign tx_en       = ovr_en ? (ovr_bits[1] & ovr_bits[0]) : txen_q;
  assign rx_en       = ovr_en ? ovr_bits[2] : rxen_q;
  assign rx_from_rx2 = ovr_en ? ovr_bits[3] : rx2_q;

endmodule

// File: rtl/trx_switch_ctl_chk.sv
module trx_switch_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic full_dup,
  input logic ovr_en,
  input logic shared_tx,
  input logic rx_from_rx2,
  input logic tx_en,
  input logic rx_en
);

  AST_TXEN_NEEDS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> shared_tx); // R10

  AST_TXEN_LAGS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && $past(!ovr_en) && $rose(shared_tx)) |-> !tx_en); // R3

  AST_SWITCH_BACK_AFTER_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && $past(!ovr_en) && $fell(shared_tx)) |-> (!tx_en && $past(!tx_en))); // R5

  AST_HALF_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && !rx_from_rx2) |-> !(rx_en && shared_tx)); // R2

  AST_FULL_MAPPING: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && $past(!ovr_en) && full_dup && $past(full_dup)) |-> (shared_tx && rx_from_rx2 && rx_en)); // R7

endmodule

bind trx_switch_ctl trx_switch_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_dup(full_dup), .ovr_en(ovr_en),
  .shared_tx(shared_tx), .rx_from_rx2(rx_from_rx2), .tx_en(tx_en), .rx_en(rx_en)
);

// File: tb/tb_trx_switch_ctl.sv
module tb_trx_switch_ctl;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_busy = 1'b0;
  logic          full_dup = 1'b0;
  logic [HW-1:0] hold_cycles = '0;
  logic          ovr_en = 1'b0;
  logic [3:0]    ovr_bits = '0;
  logic          shared_tx, rx_from_rx2, tx_en, rx_en;

  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  trx_switch_ctl #(.HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .full_dup(full_dup),
    .hold_cycles(hold_cycles), .ovr_en(ovr_en), .ovr_bits(ovr_bits),
    .shared_tx(shared_tx), .rx_from_rx2(rx_from_rx2), .tx_en(tx_en), .rx_en(rx_en)
  );

  task automatic vec(input string req, input logic e_sw, input logic e_tx,
                     input logic e_rx, input logic e_r2);
    vectors++;
    if ({shared_tx, tx_en, rx_en, rx_from_rx2} !== {e_sw, e_tx, e_rx, e_r2}) begin
      errors++;
      $display("FAIL %s: {sw,tx,rx,rx2} actual %b%b%b%b expected %b%b%b%b",
               req, shared_tx, tx_en, rx_en, rx_from_rx2, e_sw, e_tx, e_rx, e_r2);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    tx_busy = 1'b0; full_dup = 1'b0; ovr_en = 1'b0;
    repeat (24) edge1();
    vec("R5 back to idle", 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) edge1();
    vec("R1 reset state", 1'b0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    edge1();
    vec("R1 idle after reset", 1'b0, 1'b0, 1'b1, 1'b0);

    // R2 R3 R4 R5: burst length P, hold H, long quiet afterwards
    for (int h = 0; h <= 4; h++) begin
      for (int p = 1; p <= 4; p++) begin
        int m;
        m = (h == 0) ? 1 : h;
        hold_cycles = HW'(h);
        tx_busy = 1'b1;
        for (int k = 0; k <= p + m + 3; k++) begin
          logic e_sw, e_tx;
          edge1();
          e_sw = (k < p + m + 1);
          e_tx = (k >= 1) && (k < p + m);
          vec("R2 R3 R4 R5 half-duplex burst", e_sw, e_tx, !e_sw, 1'b0);
          if (k == p - 1) tx_busy = 1'b0;
        end
      end
    end

    // R6: quiet gaps of 1..M edges keep the transmit path up
    for (int h = 1; h <= 4; h++) begin
      for (int g = 1; g <= h; g++) begin
        hold_cycles = HW'(h);
        tx_busy = 1'b1;
        for (int k = 0; k <= g + 5; k++) begin
          edge1();
          if (k >= 1) vec("R6 short gap holds transmit", 1'b1, 1'b1, 1'b0, 1'b0);
          else vec("R2 switch to transmit", 1'b1, 1'b0, 1'b0, 1'b0);
          if (k == 1) tx_busy = 1'b0;
          if (k == g + 1) tx_busy = 1'b1;
        end
        settle();
      end
    end

    // R7 R8: full duplex from idle; tx_busy toggles and is ignored
    hold_cycles = HW'(2);
    full_dup = 1'b1;
    for (int k = 0; k <= 6; k++) begin
      logic e_sw, e_tx;
      edge1();
      e_sw = (k < 4);
      e_tx = (k >= 1) && (k < 3);
      vec("R7 R8 full-duplex mapping", e_sw, e_tx, 1'b1, e_sw);
      tx_busy = (k < 2) ? k[0] : 1'b0;
      if (k == 2) full_dup = 1'b0;
    end
    settle();

    // R7: full duplex entered from an active transmit burst
    tx_busy = 1'b1;
    edge1();
    edge1();
    vec("R3 transmit enable up", 1'b1, 1'b1, 1'b0, 1'b0);
    full_dup = 1'b1;
    edge1();
    vec("R7 full-duplex from transmit", 1'b1, 1'b1, 1'b1, 1'b1);
    tx_busy = 1'b0;
    edge1();
    vec("R7 tx_busy ignored in full duplex", 1'b1, 1'b1, 1'b1, 1'b1);
    settle();

    // R9 R10: all override codes
    ovr_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      ovr_bits = 4'(c);
      #1;
      vec("R9 R10 override drives lines", ovr_bits[0], ovr_bits[1] & ovr_bits[0],
          ovr_bits[2], ovr_bits[3]);
    end

    // R11: state machine tracks activity under override
    ovr_bits = 4'b0100;
    tx_busy = 1'b1;
    repeat (3) edge1();
    vec("R9 override masks transmit", 1'b0, 1'b0, 1'b1, 1'b0);
    ovr_en = 1'b0;
    #1;
    vec("R11 tracked transmit state", 1'b1, 1'b1, 1'b0, 1'b0);
    ovr_en = 1'b1;
    tx_busy = 1'b0;
    repeat (10) edge1();
    ovr_en = 1'b0;
    #1;
    vec("R11 tracked return to receive", 1'b0, 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule